// File: doc/BRIEF.md
# Binary-Trie Longest-Prefix-Match Engine

This block resolves a 32-bit destination address to a next-hop index. It walks a binary tree of node words held in on-chip storage and consumes one address bit per level, most significant bit first. Along the way it keeps the next-hop of the deepest node that carries a valid prefix, and it reports that next-hop when the walk ends. If no node on the path carried a prefix, it reports a miss together with a fixed default index.

A control port writes one whole node word per cycle. Software changes the table without stopping traffic. It first fills free nodes that no live pointer reaches, then it redirects a single child pointer to the new branch. A node write always completes in a single cycle. If a walk is in progress, the walk pauses for that cycle. Every lookup therefore follows either the complete old branch or the complete new one. After the swap, software may reuse the orphaned nodes once the walks that were already in flight have finished.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, `lk_ready` is 1 and `res_valid` is 0.
- R2: A walk starts at node 1 and tests address bit 31 first, then bit 30, and so on. A bit value of 0 follows the left pointer and 1 follows the right pointer. A pointer value of 0 means no child.
- R3: The result next-hop is the `nh` field of the deepest node on the path whose prefix-valid flag is 1, and `res_miss` is 0.
- R4: When no node on the path has its prefix-valid flag set, `res_miss` is 1 and `res_nh` equals the parameter `DEFAULT_NH` (255 by default).
- R5: The walk ends at a node whose selected child pointer is 0, or at the node at depth 32, whichever comes first. The depth-32 node is examined, and its pointers are never followed.
- R6: A node write replaces all fields of one node in one cycle. Each busy cycle that has `wr_en` high processes no node. Without writes, `res_valid` rises exactly k clock edges after the accepting edge, where k is the number of nodes on the path. Each write cycle during the walk adds one edge.
- R7: `lk_ready` is low from the accepting edge until the result is presented. A request made while `lk_ready` is low is not taken and produces no result.
- R8: Writes to nodes that no live pointer reaches leave lookup results unchanged. One write to a child pointer makes the new branch take effect for the next lookup.
- R9: `res_valid` is a single-cycle pulse for each accepted lookup, and `res_nh`/`res_miss` are valid during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one node word this cycle |
| wr_node | input | 8 | Index of the node being written |
| wr_left | input | 8 | New left child pointer (0 = none) |
| wr_right | input | 8 | New right child pointer (0 = none) |
| wr_pfx_vld | input | 1 | New prefix-valid flag |
| wr_nh | input | 8 | New next-hop index |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to resolve |
| lk_ready | output | 1 | Engine idle; a request is taken on this edge |
| res_valid | output | 1 | One-cycle result strobe |
| res_nh | output | 8 | Resolved next-hop index |
| res_miss | output | 1 | No prefix matched; `res_nh` is the default |

## Verification
A wrong internal state shows up at the ports within one lookup. A branch bit taken from the wrong end of the address, or a missed update of the best match, gives a next-hop that differs from the one derived from the table for that address. A wrong depth or stop condition gives both a wrong next-hop and a wrong edge count between acceptance and `res_valid`. A walker that reads during write cycles completes early and can follow a pointer that is being changed, so its latency is short by exactly the number of write cycles. A swapped branch that leaks into results before its linking write appears on the first lookup through that branch.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;
endpackage

// File: rtl/trie_node_mem.sv
// Node storage: one full-word write port, one asynchronous read port.
module trie_node_mem #(
  parameter int NODES  = 256,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 25
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] store_q [NODES];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/trie_walker.sv
// Iterative tree walk, one node per non-stalled cycle.
module trie_walker
  import trie_lpm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 8,
  parameter int NH_W       = 8,
  parameter int DEFAULT_NH = 255,
  parameter int ROOT       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  input  logic              stall,
  output logic [PTR_W-1:0]  node_ptr,
  input  logic [PTR_W-1:0]  node_left,
  input  logic [PTR_W-1:0]  node_right,
  input  logic              node_pv,
  input  logic [NH_W-1:0]   node_nh,
  output logic              res_valid,
  output logic [NH_W-1:0]   res_nh,
  output logic              res_miss
);
  localparam int DEPTH_W = $clog2(ADDR_W + 1);
  localparam logic [PTR_W-1:0]   ROOT_PTR = PTR_W'(ROOT);
  localparam logic [NH_W-1:0]    DEF_NH   = NH_W'(DEFAULT_NH);
  localparam logic [DEPTH_W-1:0] MAX_DEP  = DEPTH_W'(ADDR_W);

  walk_state_e         state_q, state_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic [DEPTH_W-1:0]  depth_q, depth_d;
  logic [ADDR_W-1:0]   key_q, key_d;
  logic [NH_W-1:0]     best_nh_q, best_nh_d;
  logic                best_hit_q, best_hit_d;
  logic                rv_q, rv_d;
  logic [NH_W-1:0]     rnh_q, rnh_d;
  logic                rmiss_q, rmiss_d;

  logic [PTR_W-1:0]    child;
  logic                last;

  assign child = key_q[ADDR_W-1] ? node_right : node_left;
  assign last  = (depth_q == MAX_DEP) || (child == '0);

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    depth_d    = depth_q;
    key_d      = key_q;
    best_nh_d  = best_nh_q;
    best_hit_d = best_hit_q;
    rv_d       = 1'b0;
    rnh_d      = rnh_q;
    rmiss_d    = rmiss_q;
    case (state_q)
      WALK_IDLE: begin
        if (lk_valid) begin
          state_d    = WALK_BUSY;
          ptr_d      = ROOT_PTR;
          depth_d    = '0;
          key_d      = lk_addr;
          best_nh_d  = DEF_NH;
          best_hit_d = 1'b0;
        end
      end
      WALK_BUSY: begin
        if (!stall) begin
          if (node_pv) begin
            best_nh_d  = node_nh;
            best_hit_d = 1'b1;
          end
          if (last) begin
            state_d = WALK_IDLE;
            rv_d    = 1'b1;
            rnh_d   = node_pv ? node_nh : best_nh_q;
            rmiss_d = !(node_pv || best_hit_q);
          end else begin
            ptr_d   = child;
            depth_d = depth_q + 1'b1;
            key_d   = {key_q[ADDR_W-2:0], 1'b0};
          end
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WALK_IDLE;
      ptr_q      <= '0;
      depth_q    <= '0;
      key_q      <= '0;
      best_nh_q  <= DEF_NH;
      best_hit_q <= 1'b0;
      rv_q       <= 1'b0;
      rnh_q      <= DEF_NH;
      rmiss_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      depth_q    <= depth_d;
      key_q      <= key_d;
      best_nh_q  <= best_nh_d;
      best_hit_q <= best_hit_d;
      rv_q       <= rv_d;
      rnh_q      <= rnh_d;
      rmiss_q    <= rmiss_d;
    end
  end

  assign lk_ready  = (state_q == WALK_IDLE);
  assign node_ptr  = ptr_q;
  assign res_valid = rv_q;
  assign res_nh    = rnh_q;
  assign res_miss  = rmiss_q;
endmodule

// File: rtl/trie_lpm_engine.sv
// Top: node store plus walker; writes win the store and pause the walk.
module trie_lpm_engine #(
  parameter int ADDR_W     = 32,
  parameter int NODES      = 256,
  parameter int NH_W       = 8,
  parameter int DEFAULT_NH = 255
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NODES)-1:0] wr_node,
  input  logic [$clog2(NODES)-1:0] wr_left,
  input  logic [$clog2(NODES)-1:0] wr_right,
  input  logic                     wr_pfx_vld,
  input  logic [NH_W-1:0]          wr_nh,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  output logic                     lk_ready,
  output logic                     res_valid,
  output logic [NH_W-1:0]          res_nh,
  output logic                     res_miss
);
  localparam int PTR_W  = $clog2(NODES);
  localparam int WORD_W = 2 * PTR_W + 1 + NH_W;

  logic [WORD_W-1:0] wword;
  logic [WORD_W-1:0] rword;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  rd_left;
  logic [PTR_W-1:0]  rd_right;
  logic              rd_pv;
  logic [NH_W-1:0]   rd_nh;

  assign wword = {wr_left, wr_right, wr_pfx_vld, wr_nh};
  assign {rd_left, rd_right, rd_pv, rd_nh} = rword;

  trie_node_mem #(
    .NODES (NODES),
    .PTR_W (PTR_W),
    .WORD_W(WORD_W)
  ) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_node),
    .wdata(wword),
    .raddr(rd_ptr),
    .rdata(rword)
  );

  trie_walker #(
    .ADDR_W    (ADDR_W),
    .PTR_W     (PTR_W),
    .NH_W      (NH_W),
    .DEFAULT_NH(DEFAULT_NH),
    .ROOT      (1)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_ready  (lk_ready),
    .stall     (wr_en),
    .node_ptr  (rd_ptr),
    .node_left (rd_left),
    .node_right(rd_right),
    .node_pv   (rd_pv),
    .node_nh   (rd_nh),
    .res_valid (res_valid),
    .res_nh    (res_nh),
    .res_miss  (res_miss)
  );
endmodule

// File: rtl/trie_lpm_checker.sv
module trie_lpm_checker #(
  parameter int NH_W       = 8,
  parameter int DEFAULT_NH = 255
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic            res_valid,
  input logic [NH_W-1:0] res_nh,
  input logic            res_miss
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_miss_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_nh == NH_W'(DEFAULT_NH)));

  p_idle_at_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> lk_ready);

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!lk_ready && !res_valid));

  p_write_pauses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lk_ready) |=> !res_valid);
endmodule

bind trie_lpm_engine trie_lpm_checker #(
  .NH_W      (NH_W),
  .DEFAULT_NH(DEFAULT_NH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .res_valid(res_valid),
  .res_nh   (res_nh),
  .res_miss (res_miss)
);

// File: tb/trie_lpm_engine_bench.sv
`timescale 1ns/1ps
module trie_lpm_engine_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_node, wr_left, wr_right, wr_nh;
  logic        wr_pfx_vld;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        lk_ready, res_valid, res_miss;
  logic [7:0]  res_nh;

  int n_cmp = 0;
  int n_bad = 0;

  trie_lpm_engine u_trie_lpm_engine (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_node(wr_node), .wr_left(wr_left), .wr_right(wr_right),
    .wr_pfx_vld(wr_pfx_vld), .wr_nh(wr_nh),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .res_valid(res_valid), .res_nh(res_nh), .res_miss(res_miss)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_node(input int idx, input int l, input int r,
                          input bit pv, input int nh);
    @(negedge clk);
    wr_en = 1'b1; wr_node = 8'(idx); wr_left = 8'(l); wr_right = 8'(r);
    wr_pfx_vld = pv; wr_nh = 8'(nh);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issues one lookup; extra_wr write cycles are injected right after acceptance.
  task automatic lookup(input logic [31:0] a, input int exp_nh, input bit exp_miss,
                        input int exp_steps, input int extra_wr, input string req);
    int n;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    n = 0;
    for (int w = 0; w < extra_wr; w++) begin
      wr_en = 1'b1; wr_node = 8'd250; wr_left = 8'd0; wr_right = 8'd0;
      wr_pfx_vld = 1'b1; wr_nh = 8'(w);
      @(posedge clk); @(negedge clk); n++;
    end
    wr_en = 1'b0;
    while (!res_valid && n < 200) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(res_valid == 1'b1, req, "result strobe", res_valid, 1);
    chk(res_nh == 8'(exp_nh), req, $sformatf("next-hop for %h", a), res_nh, exp_nh);
    chk(res_miss == exp_miss, req, $sformatf("miss for %h", a), res_miss, exp_miss);
    chk(n == exp_steps + extra_wr, "R6", $sformatf("latency for %h", a),
        n, exp_steps + extra_wr);
    @(posedge clk); @(negedge clk);
    chk(res_valid == 1'b0, "R9", "strobe width", res_valid, 0);
  endtask

  task automatic t_reset;
    chk(lk_ready == 1'b1, "R1", "ready after reset", lk_ready, 1);
    chk(res_valid == 1'b0, "R1", "strobe after reset", res_valid, 0);
  endtask

  task automatic t_empty_root;
    put_node(1, 0, 0, 1'b0, 0);
    lookup(32'h1234_5678, 255, 1'b1, 1, 0, "R4");
  endtask

  task automatic t_build_and_match;
    put_node(5, 0, 0, 1'b1, 50);
    put_node(4, 5, 0, 1'b0, 0);
    put_node(2, 4, 0, 1'b1, 20);
    put_node(6, 0, 0, 1'b0, 0);
    put_node(3, 0, 6, 1'b0, 0);
    put_node(1, 2, 3, 1'b0, 0);
    lookup(32'h0000_0000, 50, 1'b0, 4, 0, "R3");
    lookup(32'h3000_0000, 20, 1'b0, 3, 0, "R2");
    lookup(32'h4000_0000, 20, 1'b0, 2, 0, "R3");
    lookup(32'hC000_0000, 255, 1'b1, 3, 0, "R4");
    lookup(32'h8000_0000, 255, 1'b1, 2, 0, "R2");
  endtask

  task automatic t_full_depth;
    for (int d = 3; d <= 31; d++) put_node(d + 4, 0, d + 5, 1'b0, 0);
    put_node(36, 37, 37, 1'b1, 99);
    put_node(37, 0, 0, 1'b1, 77);
    put_node(6, 0, 7, 1'b0, 0);
    lookup(32'hFFFF_FFFF, 99, 1'b0, 33, 0, "R5");
    lookup(32'hFFFF_FFFE, 255, 1'b1, 32, 0, "R5");
  endtask

  task automatic t_write_pause;
    lookup(32'hFFFF_FFFF, 99, 1'b0, 33, 3, "R6");
  endtask

  task automatic t_busy_ignore;
    int n;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0000_0000;
    @(posedge clk); @(negedge clk);
    lk_addr = 32'hFFFF_FFFF;
    chk(lk_ready == 1'b0, "R7", "ready while busy", lk_ready, 0);
    n = 0;
    while (!res_valid && n < 200) begin
      @(posedge clk); @(negedge clk); n++;
    end
    lk_valid = 1'b0;
    chk(res_nh == 8'd50, "R7", "first request result", res_nh, 50);
    @(posedge clk); @(negedge clk);
    chk(res_valid == 1'b0 && lk_ready == 1'b1, "R7", "no second result",
        {res_valid, lk_ready}, 1);
  endtask

  task automatic t_swap;
    put_node(201, 0, 0, 1'b1, 121);
    put_node(200, 201, 0, 1'b1, 120);
    lookup(32'h0000_0000, 50, 1'b0, 4, 0, "R8");
    put_node(1, 200, 3, 1'b0, 0);
    lookup(32'h0000_0000, 121, 1'b0, 3, 0, "R8");
    lookup(32'h4000_0000, 120, 1'b0, 2, 0, "R8");
    lookup(32'hFFFF_FFFF, 99, 1'b0, 33, 0, "R8");
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_node = '0; wr_left = '0; wr_right = '0;
    wr_pfx_vld = 1'b0; wr_nh = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_root();
    t_build_and_match();
    t_full_depth();
    t_write_pause();
    t_busy_ignore();
    t_swap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule